// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block turns an oversampled asynchronous serial line into parallel characters for a CPU. A clock-enable input supplies the sampling ticks. A rate selector sets how many ticks make up one bit time. The receiver finds a falling edge on the line and confirms the start bit at its midpoint. It then samples each data bit and the stop bit at the centre of its bit time. Each completed character is placed in a holding register, and a ready flag is raised.

The CPU takes a character by pulsing a read strobe. If a new character completes while the previous one is still unread, the old one is replaced and an overrun flag is set. A stop bit that samples low sets a framing-error flag. A single error-reset pulse clears both error flags. When the line stays low through the stop positions of two characters in a row, a break output rises. It stays high until a tick samples the line high.

Top module: `async_rx_brk`

## Requirements
- R1: After reset `data_o` is 0, and `ready_o`, `overrun_o`, `frame_err_o` and `break_o` are all low.
- R2: One bit time is 4 << `rate_sel_i` ticks of `rx_tick_i` (rate codes 0..3 give 4, 8, 16 and 32). Clock cycles without a tick do not advance reception.
- R3: A character carries 5 + `len_sel_i` data bits, sent least significant bit first. The character appears right-aligned on `data_o`, and the bits above its length read 0.
- R4: The start bit is checked half a bit time after the falling edge is detected. If the line is high at that point, the event is discarded: nothing is loaded and no flag changes.
- R5: `ready_o` rises when a character is loaded and falls after a `rd_i` pulse.
- R6: If a character completes while `ready_o` is high and `rd_i` is not asserted, `data_o` takes the new character and `overrun_o` goes high.
- R7: A character whose stop bit samples low sets `frame_err_o` when it is loaded.
- R8: An `err_clr_i` pulse clears `overrun_o` and `frame_err_o`.
- R9: `break_o` rises when two consecutive characters both have a low stop bit and no tick samples the line high between them. A single low stop bit does not raise it.
- R10: `break_o` falls on the cycle after a tick that samples the line high.
- R11: While `rx_en_i` is low, no character is loaded and `ready_o` does not rise.
- R12: While `ready_o` is high and no new character completes, `data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_tick_i | input | 1 | Sampling tick (receive clock enable) |
| rxd_i | input | 1 | Serial data line, idles high |
| rx_en_i | input | 1 | Receiver enable |
| rd_i | input | 1 | CPU read strobe for the holding register |
| err_clr_i | input | 1 | Clears the overrun and framing flags |
| rate_sel_i | input | 2 | Ticks per bit, equal to 4 << code |
| len_sel_i | input | 2 | Data bits per character, equal to 5 + code |
| data_o | output | 8 | Holding register, right-aligned |
| ready_o | output | 1 | An unread character is held |
| overrun_o | output | 1 | A character was lost before being read |
| frame_err_o | output | 1 | A stop bit sampled low |
| break_o | output | 1 | Break condition detected on the line |

## Verification
The bench sends characters at every rate and length, with ticks on every cycle and on alternate cycles. A receiver that counted clock cycles instead of ticks, or aligned short characters wrongly, would return shifted or padded data. A low glitch shorter than half a bit must be rejected; a design that skipped the midpoint check would load a spurious 0xFF-style character. Two characters sent without a read must overwrite the first and set overrun. The break test holds the line low for more than two character times, and checks that the output is still low after only one low stop bit. It also checks that the output drops as soon as the line returns high. A detector that counted every low stop bit would fire too early, and one that waited for the next character would clear too late.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  localparam int unsigned MIN_CHAR_BITS = 5;
  localparam int unsigned BASE_RATE_LOG = 2;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned LEN_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              en_i,
  input  logic [SEL_W-1:0]  rate_sel_i,
  input  logic [LEN_W-1:0]  len_sel_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              stop_ok_o
);
  localparam int unsigned CNT_W = BASE_RATE_LOG + (1 << SEL_W) - 1;
  localparam int unsigned BIT_W = $clog2(DATA_W + 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bidx_q;
  logic [DATA_W-1:0] shreg_q;
  logic [CNT_W:0]    factor, half, cnt_ext;
  logic [BIT_W-1:0]  nbits, shamt;
  logic              at_half, at_end;

  always_comb begin
    factor  = (CNT_W + 1)'(1) << (int'(rate_sel_i) + BASE_RATE_LOG);
    half    = factor >> 1;
    cnt_ext = {1'b0, cnt_q};
    at_half = (cnt_ext == half - 1'b1);
    at_end  = (cnt_ext == factor - 1'b1);
    nbits   = BIT_W'(MIN_CHAR_BITS) + BIT_W'(len_sel_i);
    shamt   = BIT_W'(DATA_W) - nbits;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      bidx_q    <= '0;
      shreg_q   <= '0;
      done_o    <= 1'b0;
      data_o    <= '0;
      stop_ok_o <= 1'b1;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            if (!rxd_i) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (at_half) begin
              cnt_q  <= '0;
              bidx_q <= '0;
              // false start when the line is back high at mid-bit
              state_q <= rxd_i ? ST_IDLE : ST_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_end) begin
              cnt_q   <= '0;
              shreg_q <= {rxd_i, shreg_q[DATA_W-1:1]};
              if (bidx_q == nbits - 1'b1) state_q <= ST_STOP;
              else                        bidx_q  <= bidx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (at_end) begin
              cnt_q     <= '0;
              done_o    <= 1'b1;
              stop_ok_o <= rxd_i;
              data_o    <= shreg_q >> shamt;
              state_q   <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_hold.sv
module rx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stop_ok_i,
  input  logic              en_i,
  input  logic              rd_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              ovr_o,
  output logic              fe_o
);
  logic load;
  assign load = done_i & en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      ready_o <= 1'b0;
      ovr_o   <= 1'b0;
      fe_o    <= 1'b0;
    end else begin
      if (load)      data_o <= data_i;

      if (load)      ready_o <= 1'b1;
      else if (rd_i) ready_o <= 1'b0;

      // a new load wins over a same-cycle error reset
      if (load && ready_o && !rd_i) ovr_o <= 1'b1;
      else if (clr_i)               ovr_o <= 1'b0;

      if (load && !stop_ok_i) fe_o <= 1'b1;
      else if (clr_i)         fe_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_brk.sv
module rx_brk #(
  parameter int unsigned BRK_CHARS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rxd_i,
  input  logic done_i,
  input  logic stop_ok_i,
  output logic brk_o
);
  localparam int unsigned RUN_W = $clog2(BRK_CHARS + 1);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      brk_o <= 1'b0;
    end else if (tick_i && rxd_i) begin
      run_q <= '0;
      brk_o <= 1'b0;
    end else if (done_i) begin
      if (stop_ok_i) begin
        run_q <= '0;
      end else begin
        if (run_q == RUN_W'(BRK_CHARS - 1)) brk_o <= 1'b1;
        if (run_q != RUN_W'(BRK_CHARS))     run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/async_rx_brk.sv
module async_rx_brk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned LEN_W     = 2,
  parameter int unsigned SYNC_W    = 2,
  parameter int unsigned BRK_CHARS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_tick_i,
  input  logic              rxd_i,
  input  logic              rx_en_i,
  input  logic              rd_i,
  input  logic              err_clr_i,
  input  logic [SEL_W-1:0]  rate_sel_i,
  input  logic [LEN_W-1:0]  len_sel_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o,
  output logic              overrun_o,
  output logic              frame_err_o,
  output logic              break_o
);
  logic              rxd_s;
  logic              chr_done;
  logic              chr_stop_ok;
  logic [DATA_W-1:0] chr_data;

  rx_sync #(.STAGES(SYNC_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rxd_i),
    .q_o    (rxd_s)
  );

  rx_frame #(.DATA_W(DATA_W), .SEL_W(SEL_W), .LEN_W(LEN_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (rx_tick_i),
    .rxd_i      (rxd_s),
    .en_i       (rx_en_i),
    .rate_sel_i (rate_sel_i),
    .len_sel_i  (len_sel_i),
    .done_o     (chr_done),
    .data_o     (chr_data),
    .stop_ok_o  (chr_stop_ok)
  );

  rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (chr_done),
    .data_i    (chr_data),
    .stop_ok_i (chr_stop_ok),
    .en_i      (rx_en_i),
    .rd_i      (rd_i),
    .clr_i     (err_clr_i),
    .data_o    (data_o),
    .ready_o   (ready_o),
    .ovr_o     (overrun_o),
    .fe_o      (frame_err_o)
  );

  rx_brk #(.BRK_CHARS(BRK_CHARS)) u_brk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (rx_tick_i),
    .rxd_i     (rxd_s),
    .done_i    (chr_done),
    .stop_ok_i (chr_stop_ok),
    .brk_o     (break_o)
  );
endmodule

// File: rtl/rx_chk.sv
module rx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              rxd_s_i,
  input logic              en_i,
  input logic              rd_i,
  input logic              clr_i,
  input logic              done_i,
  input logic [DATA_W-1:0] data_i,
  input logic              ready_i,
  input logic              ovr_i,
  input logic              fe_i,
  input logic              brk_i
);
  AST_RDY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && rd_i && !done_i) |=> !ready_i); // R5

  AST_OVR_PREV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_i) |-> ($past(ready_i) && $past(done_i))); // R6

  AST_FE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fe_i) |-> $past(done_i)); // R7

  AST_ERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !done_i) |=> (!ovr_i && !fe_i)); // R8

  AST_BRK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && rxd_s_i) |=> !brk_i); // R10

  AST_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !$rose(ready_i)); // R11

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && !done_i) |=> $stable(data_i)); // R12
endmodule

bind async_rx_brk rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (rx_tick_i),
  .rxd_s_i (rxd_s),
  .en_i    (rx_en_i),
  .rd_i    (rd_i),
  .clr_i   (err_clr_i),
  .done_i  (chr_done),
  .data_i  (data_o),
  .ready_i (ready_o),
  .ovr_i   (overrun_o),
  .fe_i    (frame_err_o),
  .brk_i   (break_o)
);

// File: tb/async_rx_brk_test.sv
module async_rx_brk_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic       en = 1'b1;
  logic       rd = 1'b0;
  logic       clr = 1'b0;
  logic [1:0] rate = '0;
  logic [1:0] len = '0;
  logic [7:0] data;
  logic       ready, ovr, fe, brk;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  slow = 0;
  bit  ended = 0;

  always #5 clk = ~clk;

  async_rx_brk uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_tick_i(tick), .rxd_i(rxd),
    .rx_en_i(en), .rd_i(rd), .err_clr_i(clr), .rate_sel_i(rate),
    .len_sel_i(len), .data_o(data), .ready_o(ready), .overrun_o(ovr),
    .frame_err_o(fe), .break_o(brk)
  );

  function automatic int factor_of(logic [1:0] s);
    return 4 << s;
  endfunction

  function automatic logic [7:0] exp_char(logic [7:0] d, logic [1:0] l);
    return d & 8'((1 << (5 + l)) - 1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      if (slow) begin
        @(negedge clk);
        tick = 1'b0;
      end
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic send(logic [7:0] d, logic stop_v);
    int f;
    f = factor_of(rate);
    rxd = 1'b0;
    ticks(f);
    for (int b = 0; b < 5 + int'(len); b++) begin
      rxd = d[b];
      ticks(f);
    end
    rxd = stop_v;
    ticks(f);
    rxd = 1'b1;
    ticks(4);
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    check("R1 data", 32'(data), 0);
    check("R1 flags", {ready, ovr, fe, brk}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R5: every rate, full length
    for (int s = 0; s < 4; s++) begin
      rate = 2'(s);
      len = 2'd3;
      send(8'hA5, 1'b1);
      check("R2 ready", 32'(ready), 1);
      check("R2 data", 32'(data), 32'hA5);
      pulse_rd();
      check("R5 ready clears", 32'(ready), 0);
    end

    // R3: short length drops upper bits
    rate = 2'd1;
    len = 2'd0;
    send(8'hFF, 1'b1);
    check("R3 5-bit", 32'(data), 32'h1F);
    // R12: data holds while unread
    repeat (20) @(negedge clk);
    check("R12 hold", 32'(data), 32'h1F);
    check("R12 ready", 32'(ready), 1);
    pulse_rd();

    // random characters, ticks every cycle or every other
    for (int k = 0; k < 30; k++) begin
      rate = 2'($urandom % 4);
      len = 2'($urandom % 4);
      slow = 1'($urandom % 2);
      d = 8'($urandom % 256);
      send(d, 1'b1);
      check("R3 random data", 32'(data), 32'(exp_char(d, len)));
      check("R5 random ready", 32'(ready), 1);
      check("R7 no frame err", 32'(fe), 0);
      pulse_rd();
    end
    slow = 0;

    // R4: glitch shorter than half a bit
    rate = 2'd2;
    len = 2'd3;
    rxd = 1'b0;
    ticks(4);
    rxd = 1'b1;
    ticks(200);
    check("R4 false start", {ready, ovr, fe}, 0);
    send(8'h3C, 1'b1);
    check("R4 after glitch", 32'(data), 32'h3C);
    pulse_rd();

    // R6: overrun
    rate = 2'd0;
    d = 8'h11;
    d2 = 8'hE7;
    send(d, 1'b1);
    send(d2, 1'b1);
    check("R6 overrun", 32'(ovr), 1);
    check("R6 newest kept", 32'(data), 32'hE7);
    pulse_rd();
    pulse_clr();
    check("R8 overrun cleared", 32'(ovr), 0);

    // R7: framing error, single low stop is no break
    send(8'h5A, 1'b0);
    check("R7 frame err", 32'(fe), 1);
    check("R9 single low stop", 32'(brk), 0);
    pulse_rd();
    pulse_clr();
    check("R8 frame cleared", 32'(fe), 0);

    // R9 R10: break
    rate = 2'd0;
    len = 2'd3;
    rxd = 1'b0;
    ticks(50);
    check("R9 one char low", 32'(brk), 0);
    ticks(70);
    check("R9 break", 32'(brk), 1);
    rxd = 1'b1;
    ticks(4);
    check("R10 break clears", 32'(brk), 0);
    ticks(200);
    pulse_rd();
    pulse_clr();

    // R11: receiver disabled
    en = 1'b0;
    send(8'h77, 1'b1);
    check("R11 not loaded", 32'(ready), 0);
    en = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 stays clear", 32'(ready), 0);
    send(8'h77, 1'b1);
    check("R11 resumes", 32'(data), 32'h77);

    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule